// File: doc/BRIEF.md
# Host Compressed-Data FIFO Port

This block sits between a codec engine and a host bus and carries the compressed bitstream through a single 32-bit data register. The data register is backed by a 512-entry, 32-bit first-in first-out buffer. The direction of traffic follows a mode input:

- **Encode mode:** the engine pushes words and the host drains them by reading the data register.
- **Decode mode:** the host fills the buffer by writing the data register and the engine pops words from it.

The host may move a whole 32-bit word in one access. It may also split the word into two 16-bit accesses, low half first and high half second; only the high half moves the buffer.

Three indications serve the host:

- **Service request:** a level signal that compares the current occupancy against a programmable threshold. In encode mode it means "nearly full"; in decode mode it means "nearly empty".
- **Error:** a one-cycle pulse on overflow in encode mode, and on overflow or underflow in decode mode.
- **Last code:** in encode mode this flag tells the host that its next read returns the final word of a field. Each stored word carries the end-of-field tag supplied by the engine.

The mode input is expected to change only while reset is held.

Top module: `cdf_port`

## Requirements
- R1: After a synchronous reset, `fifo_empty` is 1, `fifo_full` is 0, `fifo_err` is 0, `last_code` is 0 and `host_rdata` is 0.
- R2: The buffer keeps words in arrival order and holds exactly 512 of them; `fifo_full` is 1 at 512 entries. The host reaches the buffer only when `host_addr` equals 8'h08. A read at any other address returns 0 and does not pop.
- R3: Encode mode (`dec_mode`=0):
  - `eng_push` stores `{eng_peof, eng_pdata}`.
  - A 32-bit host read (`host_hw`=0) returns the oldest word on `host_rdata` one cycle after `host_rd` and removes that word.
- R4: Half-word reads (`host_hw`=1) in encode mode:
  - `host_hsel`=0 returns bits 15:0 of the oldest word in `host_rdata[15:0]` and leaves the buffer unchanged.
  - `host_hsel`=1 returns bits 31:16 in `host_rdata[15:0]` and removes the word.
  - The upper 16 bits of `host_rdata` are 0 in both cases.
- R5: Half-word writes (`host_hw`=1) in decode mode:
  - A low-half write (`host_hsel`=0) stores `host_wdata[15:0]` in a holding register and does not change occupancy.
  - A high-half write (`host_hsel`=1) pushes `{host_wdata[15:0], held low half}`.
- R6: `svc_req` is 1 when occupancy >= `thr_full` in encode mode, or when occupancy <= `thr_empty` in decode mode. It follows the occupancy, with no latching.
- R7: In encode mode an engine push into a full buffer is dropped. `fifo_err` pulses high for one cycle, in the cycle after the push.
- R8: In decode mode `fifo_err` pulses for one cycle after either of these, and neither moves the buffer:
  - a host word write (32-bit, or a high-half write) into a full buffer;
  - an engine pop from an empty buffer, which also returns 0 on `eng_rdata`.
- R9: A host read of an empty buffer in encode mode returns 0 and raises no error.
- R10: `last_code` is 1 only in encode mode, while the oldest stored word carries an end-of-field tag of 1.
- R11: Encode mode ignores host writes and `eng_pop`. Decode mode ignores `eng_push`, and host reads of the data register return 0 there.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| dec_mode | input | 1 | 0 = encode (engine fills, host drains), 1 = decode (host fills, engine drains) |
| thr_full | input | 10 | Nearly-full threshold, used in encode mode |
| thr_empty | input | 10 | Nearly-empty threshold, used in decode mode |
| host_addr | input | 8 | Host register byte offset; the data register is 8'h08 |
| host_wr | input | 1 | Host write strobe |
| host_rd | input | 1 | Host read strobe |
| host_hw | input | 1 | 1 = 16-bit access, 0 = 32-bit access |
| host_hsel | input | 1 | Half select for 16-bit accesses: 0 = low half, 1 = high half |
| host_wdata | input | 32 | Host write data; half-word writes use bits 15:0 |
| host_rdata | output | 32 | Registered host read data |
| eng_push | input | 1 | Engine push (encode mode) |
| eng_pdata | input | 32 | Engine push word |
| eng_peof | input | 1 | End-of-field tag for the pushed word |
| eng_pop | input | 1 | Engine pop (decode mode) |
| eng_rdata | output | 32 | Registered engine pop data |
| fifo_full | output | 1 | Buffer holds 512 words |
| fifo_empty | output | 1 | Buffer holds no words |
| svc_req | output | 1 | Service request level |
| fifo_err | output | 1 | One-cycle overflow or underflow pulse |
| last_code | output | 1 | Next host read returns the last word of the field |

## Verification
A corrupted read or write pointer shows up as a word returned out of order or from a stale slot. This is visible on `host_rdata` or `eng_rdata` one cycle after the pop that follows the fault. A wrong occupancy count shows up on `svc_req`, `fifo_full` or `fifo_empty` in the cycle after the count diverges. It can also suppress or invent an error pulse at the 512-word or zero-word boundaries. A stale head word or a missed write bypass is caught by the first read after a push into an empty buffer. It would return old data, or `last_code` would be wrong for that word.

// File: rtl/cdf_pkg.sv
package cdf_pkg;
  localparam int CDF_DW      = 32;
  localparam int CDF_DEPTH   = 512;
  localparam int CDF_HADDR_W = 8;
  localparam int CDF_DATA_OFS = 8;

  typedef enum logic {
    DIR_ENCODE = 1'b0,
    DIR_DECODE = 1'b1
  } dir_e;
endpackage

// File: rtl/cdf_ram.sv
module cdf_ram #(
  parameter int DEPTH = 512,
  parameter int EW    = 33,
  localparam int AW   = $clog2(DEPTH)
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [EW-1:0] wdata,
  input  logic [AW-1:0] raddr,
  output logic [EW-1:0] rdata
);
  logic [EW-1:0] mem [DEPTH];

  // single write port, registered read port: block RAM friendly
  always_ff @(posedge clk) begin
    if (we) mem[waddr] <= wdata;
    rdata <= mem[raddr];
  end
endmodule

// File: rtl/cdf_ctl.sv
module cdf_ctl #(
  parameter int DEPTH = 512,
  parameter int EW    = 33,
  localparam int AW   = $clog2(DEPTH),
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          is_dec,
  input  logic          push,
  input  logic [EW-1:0] push_word,
  input  logic          pop,
  input  logic [CW-1:0] thr_full,
  input  logic [CW-1:0] thr_empty,
  output logic [EW-1:0] head,
  output logic [CW-1:0] occ,
  output logic          full,
  output logic          empty,
  output logic          srq
);
  logic [AW-1:0] wr_ptr_q, rd_ptr_q, rd_ptr_n, wr_ptr_inc, rd_ptr_inc;
  logic [CW-1:0] cnt_q, cnt_n;
  logic          push_ok, pop_ok;
  logic          byp_q;
  logic [EW-1:0] byp_word_q, ram_q;

  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;

  assign wr_ptr_inc = (wr_ptr_q == AW'(DEPTH - 1)) ? '0 : wr_ptr_q + 1'b1;
  assign rd_ptr_inc = (rd_ptr_q == AW'(DEPTH - 1)) ? '0 : rd_ptr_q + 1'b1;

  always_comb begin
    if (rst) begin
      rd_ptr_n = '0;
      cnt_n    = '0;
    end else begin
      rd_ptr_n = pop_ok ? rd_ptr_inc : rd_ptr_q;
      cnt_n    = cnt_q + CW'(push_ok) - CW'(pop_ok);
    end
  end

  cdf_ram #(.DEPTH(DEPTH), .EW(EW)) u_ram (
    .clk   (clk),
    .we    (push_ok),
    .waddr (wr_ptr_q),
    .wdata (push_word),
    .raddr (rd_ptr_n),
    .rdata (ram_q)
  );

  // the RAM returns the old word when the next head slot is written this cycle
  always_ff @(posedge clk) begin
    if (rst) begin
      wr_ptr_q <= '0;
      rd_ptr_q <= '0;
      byp_q    <= 1'b0;
    end else begin
      if (push_ok) wr_ptr_q <= wr_ptr_inc;
      rd_ptr_q <= rd_ptr_n;
      byp_q    <= push_ok && (wr_ptr_q == rd_ptr_n);
    end
    byp_word_q <= push_word;
  end

  // flags are registered from the next-state count, so they align with occ
  always_ff @(posedge clk) begin
    cnt_q <= cnt_n;
    full  <= (cnt_n == CW'(DEPTH));
    empty <= (cnt_n == '0);
    srq   <= is_dec ? (cnt_n <= thr_empty) : (cnt_n >= thr_full);
  end

  assign head = byp_q ? byp_word_q : ram_q;
  assign occ  = cnt_q;
endmodule

// File: rtl/cdf_host.sv
module cdf_host #(
  parameter int DW      = 32,
  parameter int HAW     = 8,
  parameter int DATA_OFS = 8,
  localparam int HW     = DW / 2
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           is_dec,
  input  logic [HAW-1:0] host_addr,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic           host_hw,
  input  logic           host_hsel,
  input  logic [DW-1:0]  host_wdata,
  input  logic [DW-1:0]  head_data,
  input  logic           fifo_empty,
  output logic           push_req,
  output logic [DW-1:0]  push_data,
  output logic           pop_req,
  output logic [DW-1:0]  host_rdata
);
  logic          hit, rd_fire, wr_fire;
  logic [HW-1:0] low_hold_q;
  logic [DW-1:0] rd_word;

  assign hit     = (host_addr == HAW'(DATA_OFS));
  assign rd_fire = hit && host_rd && !is_dec;
  assign wr_fire = hit && host_wr && is_dec;

  // a word moves only on a full access or on the high half of a pair
  assign pop_req   = rd_fire && (!host_hw || host_hsel);
  assign push_req  = wr_fire && (!host_hw || host_hsel);
  assign push_data = host_hw ? {host_wdata[HW-1:0], low_hold_q} : host_wdata;

  always_comb begin
    if (fifo_empty)
      rd_word = '0;
    else if (!host_hw)
      rd_word = head_data;
    else if (host_hsel)
      rd_word = {{HW{1'b0}}, head_data[DW-1:HW]};
    else
      rd_word = {{HW{1'b0}}, head_data[HW-1:0]};
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      low_hold_q <= '0;
      host_rdata <= '0;
    end else begin
      if (wr_fire && host_hw && !host_hsel) low_hold_q <= host_wdata[HW-1:0];
      host_rdata <= rd_fire ? rd_word : '0;
    end
  end
endmodule

// File: rtl/cdf_port.sv
module cdf_port
  import cdf_pkg::*;
#(
  parameter int DEPTH    = CDF_DEPTH,
  parameter int DW       = CDF_DW,
  parameter int HAW      = CDF_HADDR_W,
  parameter int DATA_OFS = CDF_DATA_OFS,
  localparam int CW      = $clog2(DEPTH + 1),
  localparam int EW      = DW + 1
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           dec_mode,
  input  logic [CW-1:0]  thr_full,
  input  logic [CW-1:0]  thr_empty,
  input  logic [HAW-1:0] host_addr,
  input  logic           host_wr,
  input  logic           host_rd,
  input  logic           host_hw,
  input  logic           host_hsel,
  input  logic [DW-1:0]  host_wdata,
  output logic [DW-1:0]  host_rdata,
  input  logic           eng_push,
  input  logic [DW-1:0]  eng_pdata,
  input  logic           eng_peof,
  input  logic           eng_pop,
  output logic [DW-1:0]  eng_rdata,
  output logic           fifo_full,
  output logic           fifo_empty,
  output logic           svc_req,
  output logic           fifo_err,
  output logic           last_code
);
  dir_e          dir;
  logic          is_dec;
  logic          h_push, h_pop;
  logic [DW-1:0] h_pdata;
  logic          push, pop;
  logic [EW-1:0] push_word, head;
  logic [CW-1:0] occ;
  logic          err_n;

  assign dir    = dir_e'(dec_mode);
  assign is_dec = (dir == DIR_DECODE);

  cdf_host #(.DW(DW), .HAW(HAW), .DATA_OFS(DATA_OFS)) u_host (
    .clk        (clk),
    .rst        (rst),
    .is_dec     (is_dec),
    .host_addr  (host_addr),
    .host_wr    (host_wr),
    .host_rd    (host_rd),
    .host_hw    (host_hw),
    .host_hsel  (host_hsel),
    .host_wdata (host_wdata),
    .head_data  (head[DW-1:0]),
    .fifo_empty (fifo_empty),
    .push_req   (h_push),
    .push_data  (h_pdata),
    .pop_req    (h_pop),
    .host_rdata (host_rdata)
  );

  // the mode picks which side fills and which side drains
  assign push      = is_dec ? h_push : eng_push;
  assign pop       = is_dec ? eng_pop : h_pop;
  assign push_word = is_dec ? {1'b0, h_pdata} : {eng_peof, eng_pdata};

  cdf_ctl #(.DEPTH(DEPTH), .EW(EW)) u_ctl (
    .clk       (clk),
    .rst       (rst),
    .is_dec    (is_dec),
    .push      (push),
    .push_word (push_word),
    .pop       (pop),
    .thr_full  (thr_full),
    .thr_empty (thr_empty),
    .head      (head),
    .occ       (occ),
    .full      (fifo_full),
    .empty     (fifo_empty),
    .srq       (svc_req)
  );

  assign err_n = is_dec ? ((h_push && fifo_full) || (eng_pop && fifo_empty))
                        : (eng_push && fifo_full);

  always_ff @(posedge clk) begin
    if (rst) begin
      fifo_err  <= 1'b0;
      eng_rdata <= '0;
    end else begin
      fifo_err <= err_n;
      if (is_dec && eng_pop) eng_rdata <= fifo_empty ? '0 : head[DW-1:0];
    end
  end

  assign last_code = !is_dec && !fifo_empty && head[EW-1];
endmodule

// File: rtl/cdf_checker.sv
module cdf_checker #(
  parameter int DEPTH = 512,
  parameter int DW    = 32,
  parameter int CW    = 10
) (
  input logic          clk,
  input logic          rst,
  input logic          dec_mode,
  input logic          eng_push,
  input logic          eng_pop,
  input logic          host_wr,
  input logic          host_rd,
  input logic [DW-1:0] eng_rdata,
  input logic          fifo_full,
  input logic          fifo_empty,
  input logic          svc_req,
  input logic          fifo_err,
  input logic          last_code,
  input logic [CW-1:0] thr_full,
  input logic [CW-1:0] thr_empty,
  input logic [CW-1:0] occ
);
  assert_flags_excl_R2: assert property (@(posedge clk) disable iff (rst)
    !(fifo_full && fifo_empty));

  assert_occ_bound_R2: assert property (@(posedge clk) disable iff (rst)
    occ <= CW'(DEPTH));

  assert_empty_matches_occ_R1: assert property (@(posedge clk) disable iff (rst)
    fifo_empty == (occ == '0));

  assert_enc_overflow_err_R7: assert property (@(posedge clk) disable iff (rst)
    !dec_mode && eng_push && fifo_full |=> fifo_err);

  assert_enc_overflow_keeps_full_R7: assert property (@(posedge clk) disable iff (rst)
    !dec_mode && eng_push && fifo_full && !host_rd |=> fifo_full);

  assert_dec_underflow_err_R8: assert property (@(posedge clk) disable iff (rst)
    dec_mode && eng_pop && fifo_empty |=> fifo_err && (eng_rdata == '0));

  assert_no_spurious_err_R8: assert property (@(posedge clk) disable iff (rst)
    !eng_push && !eng_pop && !host_wr |=> !fifo_err);

  assert_srq_level_R6: assert property (@(posedge clk) disable iff (rst)
    $stable(thr_full) && $stable(thr_empty) && $stable(dec_mode) |->
      svc_req == (dec_mode ? (occ <= thr_empty) : (occ >= thr_full)));

  assert_lcode_needs_data_R10: assert property (@(posedge clk) disable iff (rst)
    fifo_empty |-> !last_code);
endmodule

bind cdf_port cdf_checker #(.DEPTH(DEPTH), .DW(DW), .CW(CW)) u_chk (
  .clk        (clk),
  .rst        (rst),
  .dec_mode   (dec_mode),
  .eng_push   (eng_push),
  .eng_pop    (eng_pop),
  .host_wr    (host_wr),
  .host_rd    (host_rd),
  .eng_rdata  (eng_rdata),
  .fifo_full  (fifo_full),
  .fifo_empty (fifo_empty),
  .svc_req    (svc_req),
  .fifo_err   (fifo_err),
  .last_code  (last_code),
  .thr_full   (thr_full),
  .thr_empty  (thr_empty),
  .occ        (occ)
);

// File: tb/cdf_port_bench.sv
module cdf_port_bench;
  localparam int DEPTH = 512;
  localparam int CW    = 10;

  logic          clk = 1'b0;
  logic          rst = 1'b1;
  logic          dec_mode = 1'b0;
  logic [CW-1:0] thr_full = '0, thr_empty = '0;
  logic [7:0]    host_addr = '0;
  logic          host_wr = 0, host_rd = 0, host_hw = 0, host_hsel = 0;
  logic [31:0]   host_wdata = '0, host_rdata;
  logic          eng_push = 0, eng_peof = 0, eng_pop = 0;
  logic [31:0]   eng_pdata = '0, eng_rdata;
  logic          fifo_full, fifo_empty, svc_req, fifo_err, last_code;

  int n_chk = 0;
  int n_fail = 0;

  always #5 clk = ~clk;

  cdf_port u_cdf_port (
    .clk(clk), .rst(rst), .dec_mode(dec_mode), .thr_full(thr_full), .thr_empty(thr_empty),
    .host_addr(host_addr), .host_wr(host_wr), .host_rd(host_rd), .host_hw(host_hw),
    .host_hsel(host_hsel), .host_wdata(host_wdata), .host_rdata(host_rdata),
    .eng_push(eng_push), .eng_pdata(eng_pdata), .eng_peof(eng_peof), .eng_pop(eng_pop),
    .eng_rdata(eng_rdata), .fifo_full(fifo_full), .fifo_empty(fifo_empty),
    .svc_req(svc_req), .fifo_err(fifo_err), .last_code(last_code)
  );

  task automatic chk(input string req, input string what, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  // every task starts and ends just after a falling edge
  task automatic do_reset(input logic mode);
    @(negedge clk);
    dec_mode = mode;
    rst = 1'b1;
    repeat (2) @(negedge clk);
    rst = 1'b0;
  endtask

  task automatic eng_wr(input logic [31:0] d, input logic eof);
    eng_push = 1; eng_pdata = d; eng_peof = eof;
    @(negedge clk);
    eng_push = 0; eng_peof = 0;
  endtask

  task automatic eng_rd();
    eng_pop = 1;
    @(negedge clk);
    eng_pop = 0;
  endtask

  task automatic h_rd(input logic [7:0] a, input logic hw, input logic hs);
    host_addr = a; host_rd = 1; host_hw = hw; host_hsel = hs;
    @(negedge clk);
    host_rd = 0; host_hw = 0; host_hsel = 0;
  endtask

  task automatic h_wr(input logic hw, input logic hs, input logic [31:0] d);
    host_addr = 8'h08; host_wr = 1; host_hw = hw; host_hsel = hs; host_wdata = d;
    @(negedge clk);
    host_wr = 0; host_hw = 0; host_hsel = 0;
  endtask

  task automatic t_reset();
    thr_full = 10'd4;
    do_reset(1'b0);
    chk("R1", "empty after reset", 32'(fifo_empty), 1);
    chk("R1", "full after reset", 32'(fifo_full), 0);
    chk("R1", "err after reset", 32'(fifo_err), 0);
    chk("R1", "lcode after reset", 32'(last_code), 0);
    chk("R1", "rdata after reset", host_rdata, 0);
  endtask

  task automatic t_enc_basic();
    do_reset(1'b0);
    eng_wr(32'h1111_0001, 0);
    eng_wr(32'h2222_0002, 0);
    eng_wr(32'h3333_0003, 0);
    h_rd(8'h04, 0, 0);
    chk("R2", "other offset returns zero", host_rdata, 0);
    h_rd(8'h08, 0, 0);
    chk("R3", "first word", host_rdata, 32'h1111_0001);
    h_rd(8'h08, 0, 0);
    chk("R3", "second word", host_rdata, 32'h2222_0002);
    h_wr(0, 0, 32'hBAD0_BAD0);
    eng_pop = 1; @(negedge clk); eng_pop = 0;
    h_rd(8'h08, 0, 0);
    chk("R11", "encode ignores host write and eng_pop", host_rdata, 32'h3333_0003);
    chk("R11", "empty after last read", 32'(fifo_empty), 1);
  endtask

  task automatic t_enc_half();
    do_reset(1'b0);
    eng_wr(32'hAABB_CCDD, 0);
    h_rd(8'h08, 1, 0);
    chk("R4", "low half", host_rdata, 32'h0000_CCDD);
    chk("R4", "low half keeps word", 32'(fifo_empty), 0);
    h_rd(8'h08, 1, 1);
    chk("R4", "high half", host_rdata, 32'h0000_AABB);
    chk("R4", "high half pops", 32'(fifo_empty), 1);
  endtask

  task automatic t_lcode();
    do_reset(1'b0);
    eng_wr(32'hA, 0);
    eng_wr(32'hB, 1);
    chk("R10", "untagged head", 32'(last_code), 0);
    h_rd(8'h08, 0, 0);
    chk("R10", "word before last", host_rdata, 32'hA);
    chk("R10", "tagged head", 32'(last_code), 1);
    h_rd(8'h08, 0, 0);
    chk("R10", "last word", host_rdata, 32'hB);
    chk("R10", "cleared when empty", 32'(last_code), 0);
  endtask

  task automatic t_enc_srq();
    do_reset(1'b0);
    thr_full = 10'd4;
    for (int i = 0; i < 3; i++) eng_wr(32'(i), 0);
    chk("R6", "below encode threshold", 32'(svc_req), 0);
    eng_wr(32'h4, 0);
    chk("R6", "at encode threshold", 32'(svc_req), 1);
    h_rd(8'h08, 0, 0);
    chk("R6", "drops after read", 32'(svc_req), 0);
  endtask

  task automatic t_enc_overflow();
    int bad;
    do_reset(1'b0);
    thr_full = 10'd512;
    for (int i = 0; i < DEPTH; i++) eng_wr(32'h1000_0000 + 32'(i), 0);
    chk("R2", "full at 512", 32'(fifo_full), 1);
    chk("R6", "srq at 512", 32'(svc_req), 1);
    chk("R7", "no err before overflow", 32'(fifo_err), 0);
    eng_wr(32'hDEAD_BEEF, 0);
    chk("R7", "overflow err pulse", 32'(fifo_err), 1);
    @(negedge clk);
    chk("R7", "err one cycle", 32'(fifo_err), 0);
    bad = 0;
    for (int i = 0; i < DEPTH; i++) begin
      h_rd(8'h08, 0, 0);
      if (host_rdata !== 32'h1000_0000 + 32'(i)) bad++;
    end
    chk("R2", "order over 512 words, dropped word absent", 32'(bad), 0);
    h_rd(8'h08, 0, 0);
    chk("R9", "empty read zero", host_rdata, 0);
    chk("R9", "empty read no err", 32'(fifo_err), 0);
  endtask

  task automatic t_dec_basic();
    thr_empty = 10'd2;
    do_reset(1'b1);
    chk("R6", "decode srq at zero", 32'(svc_req), 1);
    eng_wr(32'h5555_5555, 0);
    chk("R11", "decode ignores eng_push", 32'(fifo_empty), 1);
    h_wr(1, 0, 32'h0000_1234);
    chk("R5", "low half holds", 32'(fifo_empty), 1);
    h_wr(1, 1, 32'h0000_5678);
    chk("R5", "high half pushes", 32'(fifo_empty), 0);
    h_wr(0, 0, 32'hCAFE_F00D);
    chk("R6", "decode srq at threshold", 32'(svc_req), 1);
    h_wr(0, 0, 32'h0BAD_CAFE);
    chk("R6", "decode srq above threshold", 32'(svc_req), 0);
    h_rd(8'h08, 0, 0);
    chk("R11", "decode host read zero", host_rdata, 0);
    eng_rd();
    chk("R5", "paired halves", eng_rdata, 32'h5678_1234);
    chk("R6", "decode srq after pop", 32'(svc_req), 1);
    eng_rd();
    chk("R3", "decode word order", eng_rdata, 32'hCAFE_F00D);
    chk("R10", "no lcode in decode", 32'(last_code), 0);
  endtask

  task automatic t_dec_errors();
    do_reset(1'b1);
    eng_rd();
    chk("R8", "underflow err", 32'(fifo_err), 1);
    chk("R8", "underflow data zero", eng_rdata, 0);
    for (int i = 0; i < DEPTH; i++) h_wr(0, 0, 32'(i));
    chk("R8", "decode full", 32'(fifo_full), 1);
    chk("R8", "no err while filling", 32'(fifo_err), 0);
    h_wr(0, 0, 32'hFFFF_FFFF);
    chk("R8", "decode overflow err", 32'(fifo_err), 1);
    eng_rd();
    chk("R8", "head intact after overflow", eng_rdata, 0);
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    n_chk++; n_fail++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

  initial begin : main
    t_reset();
    t_enc_basic();
    t_enc_half();
    t_lcode();
    t_enc_srq();
    t_enc_overflow();
    t_dec_basic();
    t_dec_errors();
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule